// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Scanner

This block drives a row of four seven-segment displays that share one set of segment lines and are selected one at a time through individual column enables. It takes four 4-bit values, turns each into a hexadecimal glyph, and shows them one after another. Switching is fast enough that the eye sees all four digits lit at once.

Scan speed comes from an external periodic strobe. A prescaler counts the strobes and moves the scan on by one column for every twentieth strobe. With a strobe rate of twenty per millisecond, that is one column per millisecond.

Each column change follows a break-before-make order. All columns are first switched off. One cycle later the new glyph is loaded. One cycle after that the new column is switched on. A segment pattern meant for one digit therefore never lights on another.

Top module: `hexscan_top`

## Requirements
- R1: While `rst` is high at a clock edge, `seg_o` becomes 8'hFF and `col_o` becomes 4'b0000. Reset also returns the scan position to its starting point and the prescaler to its full count.
- R2: An advance happens on exactly every 20th clock edge at which `tick_i` is high, counting from reset. Edges with `tick_i` low do not count, and the outputs keep their values between advances.
- R3: The first advance after reset shows digit 0 on column 4'b0001.
- R4: Every later advance follows the repeating column order 4'b1000, 4'b0100, 4'b0010, 4'b0001. Those columns show digits 0, 1, 2 and 3 respectively. Digit k is `digits_i[4k+3:4k]`.
- R5: The edge that counts the 20th strobe drives `col_o` to zero. The next edge loads the new glyph on `seg_o`. The edge after that drives the new column. `col_o` never moves directly from one nonzero value to another, and `seg_o` changes only while `col_o` is zero.
- R6: Segments are active low, so a 0 bit lights a segment. For nibble values 0 to F the glyph bytes are, in order: 05, DD, 86, 94, 5C, 34, 24, 9D, 04, 14, 0C, 64, 27, C4, 26, 2E (hex).
- R7: At most one bit of `col_o` is ever set.
- R8: A digit value is sampled only at the edge that loads the glyph. A change of `digits_i` at any other time leaves `seg_o` unchanged until the next advance that selects that digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic strobe, one clock wide, counted by the prescaler |
| digits_i | input | 16 | Four nibbles; digit k in bits 4k+3 to 4k |
| seg_o | output | 8 | Active-low segment byte |
| col_o | output | 4 | One-hot column enable, all zero while blanked |

## Verification
Strobes are applied back to back, with gaps of one and three idle cycles, and as a single isolated 19-strobe run. This shows that the prescaler counts strobes and not clock cycles, and that it fires on the twentieth strobe and not before. Two digit sets with distinct values are used so that a wrong column-to-digit pairing or a skipped position in the scan order shows up. A sweep of all sixteen nibble values through every digit checks the full glyph table.

The digits are changed between advances to confirm that the value is taken only at the glyph-load edge. A reset in the middle of the scan confirms that the special first column comes back. A reference model compares `seg_o` and `col_o` on every clock, which catches any reordering of the blank, load and enable steps.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 8;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SEG_W-1:0] seg_t;

    // all segments dark (active low)
    localparam seg_t SEG_DARK = 8'hFF;

    // scan phases after an advance request
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // columns showing, waiting for a step
        PH_PAINT = 2'd1,   // columns dark, glyph to be loaded
        PH_SHOW  = 2'd2    // glyph loaded, column to be enabled
    } phase_e;

    // active-low hex glyph for one nibble
    function automatic seg_t glyph_of(input nib_t n);
        seg_t g;
        case (n)
            4'h0: g = 8'h05;
            4'h1: g = 8'hDD;
            4'h2: g = 8'h86;
            4'h3: g = 8'h94;
            4'h4: g = 8'h5C;
            4'h5: g = 8'h34;
            4'h6: g = 8'h24;
            4'h7: g = 8'h9D;
            4'h8: g = 8'h04;
            4'h9: g = 8'h14;
            4'hA: g = 8'h0C;
            4'hB: g = 8'h64;
            4'hC: g = 8'h27;
            4'hD: g = 8'hC4;
            4'hE: g = 8'h26;
            default: g = 8'h2E;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hexscan_prescale.sv
module hexscan_prescale #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic step_o
);
    localparam int CNT_W = $clog2(DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    // a step fires on the strobe that brings the count to expiry
    assign step_o = tick_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(DIV);
        end else if (tick_i) begin
            if (cnt_q == CNT_W'(1)) cnt_q <= CNT_W'(DIV);
            else                    cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(DIV))) else $error("count range"); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q)) else $error("count moved without strobe"); // R2

endmodule

// File: rtl/hexscan_glyph.sv
module hexscan_glyph
    import hexscan_pkg::*;
(
    input  nib_t nib_i,
    output seg_t seg_o
);
    assign seg_o = glyph_of(nib_i);
endmodule

// File: rtl/hexscan_seq.sv
module hexscan_seq
    import hexscan_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_i,
    input  logic [N-1:0][SEG_W-1:0] glyphs_i,
    output seg_t                    seg_o,
    output logic [N-1:0]            col_o
);
    localparam int IDX_W = $clog2(N);
    localparam logic [N-1:0] COL_FIRST = N'(1);
    localparam logic [N-1:0] COL_TOP   = {1'b1, {(N-1){1'b0}}};

    phase_e          ph_q;
    logic [N-1:0]    next_col_q;
    logic [IDX_W-1:0] idx_q;
    seg_t            seg_q;
    logic [N-1:0]    col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            next_col_q <= COL_FIRST;
            idx_q      <= '0;
            seg_q      <= SEG_DARK;
            col_q      <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (step_i) begin
                        col_q <= '0;          // break first
                        ph_q  <= PH_PAINT;
                    end
                end
                PH_PAINT: begin
                    seg_q <= glyphs_i[idx_q];
                    ph_q  <= PH_SHOW;
                end
                PH_SHOW: begin
                    col_q <= next_col_q;      // make last
                    if (next_col_q[0]) begin
                        next_col_q <= COL_TOP;
                        idx_q      <= '0;
                    end else begin
                        next_col_q <= next_col_q >> 1;
                        idx_q      <= idx_q + IDX_W'(1);
                    end
                    ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign seg_o = seg_q;
    assign col_o = col_q;

    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_o)) else $error("several columns"); // R7

    AST_SEG_DARKCOL: assert property (@(posedge clk) disable iff (rst)
        (seg_o != $past(seg_o)) |-> (col_o == '0)) else $error("seg moved while lit"); // R5

    AST_COL_VIA_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((col_o != '0) && (col_o != $past(col_o))) |-> ($past(col_o) == '0))
        else $error("column switched without blank"); // R5

    AST_BLANK_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_i && (ph_q == PH_IDLE)) |=> (col_o == '0)) else $error("no blank"); // R5

endmodule

// File: rtl/hexscan_top.sv
module hexscan_top
    import hexscan_pkg::*;
#(
    parameter int N_DIGITS = 4,
    parameter int DIV      = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_i,
    input  logic [N_DIGITS*NIB_W-1:0] digits_i,
    output logic [SEG_W-1:0]          seg_o,
    output logic [N_DIGITS-1:0]       col_o
);
    logic                           step;
    logic [N_DIGITS-1:0][SEG_W-1:0] glyphs;

    hexscan_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .step_o (step)
    );

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_dec
        hexscan_glyph u_gl (
            .nib_i (digits_i[k*NIB_W +: NIB_W]),
            .seg_o (glyphs[k])
        );
    end

    hexscan_seq #(.N(N_DIGITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .glyphs_i (glyphs),
        .seg_o    (seg_o),
        .col_o    (col_o)
    );

endmodule

// File: tb/sim_hexscan_top.sv
module sim_hexscan_top;
    localparam int CLK_NS = 10;
    localparam int DIV    = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [15:0] digits_i = 16'h0000;
    logic [7:0]  seg_o;
    logic [3:0]  col_o;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;

    logic [7:0] gl [16];

    hexscan_top u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .digits_i(digits_i), .seg_o(seg_o), .col_o(col_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    // reference model: behavioural scan schedule
    int m_cnt, m_ph, m_bit, m_idx, ph0;
    logic [7:0] e_seg;
    logic [3:0] e_col;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = DIV; m_ph = 0; m_bit = 0; m_idx = 0;
            e_seg = 8'hFF; e_col = 4'b0000;
        end else begin
            ph0 = m_ph;
            if (ph0 == 1) begin
                e_seg = gl[digits_i[4*m_idx +: 4]];
                m_ph = 2;
            end else if (ph0 == 2) begin
                e_col = 4'(1 << m_bit);
                if (m_bit == 0) begin m_bit = 3; m_idx = 0; end
                else begin m_bit = m_bit - 1; m_idx = m_idx + 1; end
                m_ph = 0;
            end
            if (tick_i) begin
                if (m_cnt == 1) begin
                    m_cnt = DIV;
                    if (ph0 == 0) begin e_col = 4'b0000; m_ph = 1; end
                end else m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check("R5 col per cycle", 32'(col_o), 32'(e_col));
            check("R6 seg per cycle", 32'(seg_o), 32'(e_seg));
            check("R7 onehot0", 32'($onehot0(col_o)), 32'd1);
        end
    end

    // DIV strobes separated by 'gap' idle cycles, then wait until the column is on
    task automatic advance(input int gap);
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk) tick_i = 1'b1;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk) tick_i = 1'b0;
            end
        end
        @(negedge clk) tick_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        tick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        gl = '{8'h05, 8'hDD, 8'h86, 8'h94, 8'h5C, 8'h34, 8'h24, 8'h9D,
               8'h04, 8'h14, 8'h0C, 8'h64, 8'h27, 8'hC4, 8'h26, 8'h2E};
        digits_i = 16'h4321;   // d0=1 d1=2 d2=3 d3=4
        do_reset();
        @(negedge clk);
        check("R1 seg after reset", 32'(seg_o), 32'hFF);
        check("R1 col after reset", 32'(col_o), 32'h0);
        cmp_on = 1'b1;

        // R2: 19 strobes must not advance
        for (int i = 0; i < DIV-1; i++) begin
            @(negedge clk) tick_i = 1'b1;
        end
        @(negedge clk) tick_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 no step at 19 strobes col", 32'(col_o), 32'h0);
        check("R2 no step at 19 strobes seg", 32'(seg_o), 32'hFF);

        // R5: 20th strobe, watch each phase
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        check("R5 blank after step", 32'(col_o), 32'h0);
        check("R5 seg not yet loaded", 32'(seg_o), 32'hFF);
        @(negedge clk);
        check("R5 glyph loaded while dark", 32'(seg_o), 32'(gl[1]));
        check("R5 still dark", 32'(col_o), 32'h0);
        @(negedge clk);
        check("R3 first column", 32'(col_o), 32'b0001);

        // R4: order with back-to-back strobes
        advance(0);
        check("R4 col d0", 32'(col_o), 32'b1000);
        check("R4 seg d0", 32'(seg_o), 32'(gl[1]));
        advance(1);
        check("R4 col d1", 32'(col_o), 32'b0100);
        check("R4 seg d1", 32'(seg_o), 32'(gl[2]));
        advance(3);
        check("R4 col d2", 32'(col_o), 32'b0010);
        check("R4 seg d2", 32'(seg_o), 32'(gl[3]));
        advance(0);
        check("R4 col d3", 32'(col_o), 32'b0001);
        check("R4 seg d3", 32'(seg_o), 32'(gl[4]));

        // R8: change digits between advances
        digits_i = 16'hBEAF;
        repeat (5) @(negedge clk);
        check("R8 seg held after digit change", 32'(seg_o), 32'(gl[4]));
        check("R8 col held after digit change", 32'(col_o), 32'b0001);
        advance(1);
        check("R8 new d0 shown", 32'(seg_o), 32'(gl[4'hF]));
        check("R4 wrap col", 32'(col_o), 32'b1000);
        advance(0);
        check("R8 new d1 shown", 32'(seg_o), 32'(gl[4'hA]));

        // R1/R3: reset mid-scan restores first column
        do_reset();
        @(negedge clk);
        check("R1 seg after mid reset", 32'(seg_o), 32'hFF);
        check("R1 col after mid reset", 32'(col_o), 32'h0);
        digits_i = 16'h5678;
        advance(0);
        check("R3 first column again", 32'(col_o), 32'b0001);
        check("R3 first digit again", 32'(seg_o), 32'(gl[8]));

        // R6: full glyph sweep
        for (int v = 0; v < 16; v++) begin
            digits_i = {4{4'(v)}};
            advance(0);
            check("R6 glyph sweep", 32'(seg_o), 32'(gl[v]));
        end

        cmp_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule